// File: doc/BRIEF.md
# Byte/Word Integer ALU with Status Flags

This block is the combinational arithmetic and logic stage of a small 16-bit RISC core. Each call takes a source operand, a destination operand, the stored carry flag, a byte/word select and a five-bit operation code. It returns the result, a flag that says whether that result should be written back, the next value for each of the four condition flags, and a per-flag update enable. Register writeback, memory operands, push and call are handled elsewhere.

The operation code has two groups. Codes 0x04 to 0x0F are the two-operand operations. Codes 0x10 to 0x13 are the single-operand shift, swap and extend group, and these act on the destination operand. Any other code is undefined and has no effect. In byte mode only the low eight bits of each operand take part, the upper byte of the result is forced to zero, and the flags are taken at bit 7. The block contains no state and no clock.

Top module: `bw_alu`

## Requirements
- R1: Operation codes are: move 0x04, add 0x05, add-with-carry 0x06, subtract-with-carry 0x07, subtract 0x08, compare 0x09, decimal add 0x0A, bit-test 0x0B, bit-clear 0x0C, bit-set 0x0D, XOR 0x0E, AND 0x0F, rotate-right-through-carry 0x10, swap-bytes 0x11, arithmetic-right-shift 0x12 and sign-extend 0x13. `wr_en_o` is 1 for every defined code except compare and bit-test. Any other code gives `res_o`=0, `wr_en_o`=0 and `flag_we_o`=0.
- R2: Add returns dst+src. Add-with-carry returns dst+src+`carry_i`. `carry_i` affects only add-with-carry, subtract-with-carry and rotate-through-carry.
- R3: Subtract and compare compute dst+~src+1. Subtract-with-carry computes dst+~src+`carry_i`. Compare still drives the difference on `res_o`.
- R4: Decimal add adds dst, src and `carry_i` as packed BCD digits. Its carry is set when the sum exceeds 99 in byte mode or 9999 in word mode.
- R5: Bit-clear returns ~src AND dst. Bit-set returns src OR dst. Move returns src. AND and XOR are the plain bitwise operations, and bit-test returns src AND dst.
- R6: Rotate-through-carry shifts dst right by one, puts `carry_i` into the top bit of the selected width and moves the old bit 0 into C. Arithmetic shift keeps the top bit and moves bit 0 into C.
- R7: Swap-bytes exchanges the two bytes of dst. Sign-extend copies dst bit 7 into bits 15:8. Both always act on the whole word, whatever the value of `byte_i`.
- R8: When `byte_i`=1, only the low bytes of the operands are used, `res_o[15:8]` is 0, and carry and overflow are taken at bit 7.
- R9: `flag_o` and `flag_we_o` use the bit order C=bit 0, Z=bit 1, N=bit 2, V=bit 3. N is the top bit of the result at the selected width and Z is set when the result is zero. Any `flag_o` bit whose enable is 0 reads 0.
- R10: For add, add-with-carry, subtract, subtract-with-carry and compare, all four flags update. C is the carry out, and V is set when both adder inputs have the same sign and the result has the other sign.
- R11: AND, bit-test, XOR, sign-extend and the two shifts update all four flags. For AND, bit-test, XOR and sign-extend, C is the inverse of Z. V is 0, except for XOR, where V is set when both operands are negative.
- R12: Move, swap-bytes, bit-clear and bit-set update no flag. Decimal add updates N, Z and C but not V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand; the only operand used by the single-operand group |
| carry_i | input | 1 | Carry flag currently stored in the status register |
| byte_i | input | 1 | 1 selects byte width, 0 selects word width |
| op_i | input | 5 | Operation code (see R1) |
| res_o | output | 16 | Result |
| wr_en_o | output | 1 | The result should be written to the destination |
| flag_o | output | 4 | Next flag values {V,N,Z,C} |
| flag_we_o | output | 4 | Per-flag update enables {V,N,Z,C} |

## Verification
All outputs depend combinationally on the inputs, so every result, write enable and flag value is due in the same cycle the stimulus is applied, with no register in the path. The bench drives each stimulus on the falling clock edge and samples the outputs one nanosecond later, well before the next rising edge. Each stimulus is therefore checked on its own, with no carry-over from earlier vectors. A table walks every operation code in both widths, and directed checks cover the idle state, undefined codes and the carry and overflow boundaries.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

   typedef enum logic [4:0] {
      OP_MOV  = 5'h04,
      OP_ADD  = 5'h05,
      OP_ADDC = 5'h06,
      OP_SUBC = 5'h07,
      OP_SUB  = 5'h08,
      OP_CMP  = 5'h09,
      OP_DADD = 5'h0A,
      OP_BIT  = 5'h0B,
      OP_BIC  = 5'h0C,
      OP_BIS  = 5'h0D,
      OP_XOR  = 5'h0E,
      OP_AND  = 5'h0F,
      OP_RRC  = 5'h10,
      OP_SWPB = 5'h11,
      OP_RRA  = 5'h12,
      OP_SXT  = 5'h13
   } alu_op_e;

   // operation classes, chosen by how each class sets the flags
   typedef enum logic [2:0] {
      CL_UNDEF,
      CL_ARITH,
      CL_DEC,
      CL_TEST,
      CL_SHIFT,
      CL_QUIET
   } alu_class_e;

   localparam int FLG_C = 0;
   localparam int FLG_Z = 1;
   localparam int FLG_N = 2;
   localparam int FLG_V = 3;
   localparam int FLG_W = 4;

endpackage

// File: rtl/bw_alu_addsub.sv
module bw_alu_addsub #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              byte_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o,
   output logic              ovf_o
);
   localparam int HI_W = DATA_W - BYTE_W;

   logic [DATA_W:0] wsum;
   logic [BYTE_W:0] bsum;
   logic            sa, sb, sr;

   assign wsum = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
   assign bsum = {1'b0, a_i[BYTE_W-1:0]} + {1'b0, b_i[BYTE_W-1:0]}
               + {{BYTE_W{1'b0}}, cin_i};

   always_comb begin
      if (byte_i) begin
         sum_o  = {{HI_W{1'b0}}, bsum[BYTE_W-1:0]};
         cout_o = bsum[BYTE_W];
         sa     = a_i[BYTE_W-1];
         sb     = b_i[BYTE_W-1];
         sr     = bsum[BYTE_W-1];
      end else begin
         sum_o  = wsum[DATA_W-1:0];
         cout_o = wsum[DATA_W];
         sa     = a_i[DATA_W-1];
         sb     = b_i[DATA_W-1];
         sr     = wsum[DATA_W-1];
      end
      ovf_o = (sa == sb) && (sr != sa);
   end

   // R10: the carry must be consistent with an independent sum (no inverted operand case)
   always_comb begin
      if (!byte_i && !cin_i)
         AST_ADD_CARRY_WORD: assert (cout_o == ((a_i + b_i) < a_i)); // R10
   end

endmodule

// File: rtl/bw_alu_bcd.sv
module bw_alu_bcd #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              byte_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o
);
   localparam int NDIG = DATA_W / 4;
   localparam int BDIG = BYTE_W / 4;
   localparam int HI_W = DATA_W - BYTE_W;

   logic [NDIG:0]       cy;
   logic [DATA_W-1:0]   raw;

   assign cy[0] = cin_i;

   for (genvar d = 0; d < NDIG; d++) begin : g_digit
      logic [4:0] dsum;
      logic       dgt;
      logic [4:0] dadj;
      assign dsum = {1'b0, a_i[4*d +: 4]} + {1'b0, b_i[4*d +: 4]} + {4'b0, cy[d]};
      assign dgt  = dsum > 5'd9;
      assign dadj = dgt ? (dsum - 5'd10) : dsum;
      assign raw[4*d +: 4] = dadj[3:0];
      assign cy[d+1] = dgt;
   end

   assign sum_o  = byte_i ? {{HI_W{1'b0}}, raw[BYTE_W-1:0]} : raw;
   assign cout_o = byte_i ? cy[BDIG] : cy[NDIG];

endmodule

// File: rtl/bw_alu_logic.sv
module bw_alu_logic
   import bw_alu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic              cin_i,
   input  logic              byte_i,
   input  logic [4:0]        op_i,
   output logic [DATA_W-1:0] res_o,
   output logic              shout_o
);
   localparam int HI_W = DATA_W - BYTE_W;

   logic [DATA_W-1:0] full;
   logic [BYTE_W-1:0] dlo;

   assign dlo = dst_i[BYTE_W-1:0];

   always_comb begin
      full    = '0;
      shout_o = dst_i[0];
      case (op_i)
         OP_MOV: full = src_i;
         OP_AND,
         OP_BIT: full = src_i & dst_i;
         OP_XOR: full = src_i ^ dst_i;
         OP_BIS: full = src_i | dst_i;
         OP_BIC: full = ~src_i & dst_i;
         OP_RRC: full = byte_i ? {{HI_W{1'b0}}, cin_i, dlo[BYTE_W-1:1]}
                               : {cin_i, dst_i[DATA_W-1:1]};
         OP_RRA: full = byte_i ? {{HI_W{1'b0}}, dlo[BYTE_W-1], dlo[BYTE_W-1:1]}
                               : {dst_i[DATA_W-1], dst_i[DATA_W-1:1]};
         OP_SWPB: full = {dst_i[BYTE_W-1:0], dst_i[DATA_W-1:BYTE_W]};
         OP_SXT:  full = {{HI_W{dlo[BYTE_W-1]}}, dlo};
         default: full = '0;
      endcase
      res_o = byte_i ? {{HI_W{1'b0}}, full[BYTE_W-1:0]} : full;
   end

endmodule

// File: rtl/bw_alu.sv
module bw_alu
   import bw_alu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int BYTE_W     = 8,
   parameter bit DECIMAL_EN = 1'b1
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic              carry_i,
   input  logic              byte_i,
   input  logic [4:0]        op_i,
   output logic [DATA_W-1:0] res_o,
   output logic              wr_en_o,
   output logic [FLG_W-1:0]  flag_o,
   output logic [FLG_W-1:0]  flag_we_o
);
   localparam int HI_W = DATA_W - BYTE_W;

   if (DATA_W != 2 * BYTE_W) begin : g_bad_width
      $error("bw_alu: DATA_W must be twice BYTE_W");
   end
   if (BYTE_W % 4 != 0) begin : g_bad_byte
      $error("bw_alu: BYTE_W must hold whole BCD digits");
   end

   alu_class_e        cls;
   logic [DATA_W-1:0] add_b;
   logic              add_c;
   logic              byte_eff;
   logic [DATA_W-1:0] add_sum, dec_sum, lg_res;
   logic              add_cout, add_ovf, dec_cout, lg_shout;
   logic              res_zero, res_neg, src_neg, dst_neg;
   logic [FLG_W-1:0]  flag_raw;

   // decode: class and adder operand shaping
   always_comb begin
      cls   = CL_UNDEF;
      add_b = src_i;
      add_c = 1'b0;
      case (op_i)
         OP_ADD:  cls = CL_ARITH;
         OP_ADDC: begin cls = CL_ARITH; add_c = carry_i; end
         OP_SUB,
         OP_CMP:  begin cls = CL_ARITH; add_b = ~src_i; add_c = 1'b1; end
         OP_SUBC: begin cls = CL_ARITH; add_b = ~src_i; add_c = carry_i; end
         OP_DADD: begin cls = DECIMAL_EN ? CL_DEC : CL_UNDEF; add_c = carry_i; end
         OP_AND,
         OP_BIT,
         OP_XOR:  cls = CL_TEST;
         OP_RRC,
         OP_RRA,
         OP_SXT:  cls = CL_SHIFT;
         OP_MOV,
         OP_SWPB,
         OP_BIC,
         OP_BIS:  cls = CL_QUIET;
         default: cls = CL_UNDEF;
      endcase
   end

   // swap and sign-extend are word-only operations
   assign byte_eff = byte_i && (op_i != OP_SWPB) && (op_i != OP_SXT);

   bw_alu_addsub #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_addsub (
      .a_i    (dst_i),
      .b_i    (add_b),
      .cin_i  (add_c),
      .byte_i (byte_eff),
      .sum_o  (add_sum),
      .cout_o (add_cout),
      .ovf_o  (add_ovf)
   );

   if (DECIMAL_EN) begin : g_dec
      bw_alu_bcd #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bcd (
         .a_i    (dst_i),
         .b_i    (src_i),
         .cin_i  (add_c),
         .byte_i (byte_eff),
         .sum_o  (dec_sum),
         .cout_o (dec_cout)
      );
   end else begin : g_nodec
      assign dec_sum  = '0;
      assign dec_cout = 1'b0;
   end

   bw_alu_logic #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_logic (
      .src_i   (src_i),
      .dst_i   (dst_i),
      .cin_i   (carry_i),
      .byte_i  (byte_eff),
      .op_i    (op_i),
      .res_o   (lg_res),
      .shout_o (lg_shout)
   );

   // result select and write enable
   always_comb begin
      case (cls)
         CL_ARITH: res_o = add_sum;
         CL_DEC:   res_o = dec_sum;
         CL_TEST,
         CL_SHIFT,
         CL_QUIET: res_o = lg_res;
         default:  res_o = '0;
      endcase
      wr_en_o = (cls != CL_UNDEF) && (op_i != OP_CMP) && (op_i != OP_BIT);
   end

   assign res_zero = (res_o == '0);
   assign res_neg  = byte_eff ? res_o[BYTE_W-1] : res_o[DATA_W-1];
   assign src_neg  = byte_eff ? src_i[BYTE_W-1] : src_i[DATA_W-1];
   assign dst_neg  = byte_eff ? dst_i[BYTE_W-1] : dst_i[DATA_W-1];

   // flag generation
   always_comb begin
      flag_raw        = '0;
      flag_we_o       = '0;
      flag_raw[FLG_N] = res_neg;
      flag_raw[FLG_Z] = res_zero;
      case (cls)
         CL_ARITH: begin
            flag_we_o       = 4'b1111;
            flag_raw[FLG_C] = add_cout;
            flag_raw[FLG_V] = add_ovf;
         end
         CL_DEC: begin
            flag_we_o       = 4'b0111;
            flag_raw[FLG_C] = dec_cout;
         end
         CL_TEST: begin
            flag_we_o       = 4'b1111;
            flag_raw[FLG_C] = !res_zero;
            flag_raw[FLG_V] = (op_i == OP_XOR) && src_neg && dst_neg;
         end
         CL_SHIFT: begin
            flag_we_o       = 4'b1111;
            flag_raw[FLG_C] = (op_i == OP_SXT) ? !res_zero : lg_shout;
         end
         default: flag_we_o = '0;
      endcase
      flag_o = flag_raw & flag_we_o;
   end

   // checks on the assembled outputs
   always_comb begin
      if (byte_eff)
         AST_BYTE_UPPER_CLEAR: assert (res_o[DATA_W-1:BYTE_W] == {HI_W{1'b0}}); // R8
      AST_FLAG_MASKED: assert ((flag_o & ~flag_we_o) == '0); // R9
      if (op_i == OP_CMP || op_i == OP_BIT)
         AST_NO_WRITE_ON_TEST: assert (!wr_en_o); // R1
      if (op_i == OP_AND || op_i == OP_BIT || op_i == OP_XOR)
         AST_LOGIC_CARRY_NOT_ZERO: assert (flag_o[FLG_C] == !flag_o[FLG_Z]); // R11
      if (op_i == OP_MOV || op_i == OP_SWPB || op_i == OP_BIC || op_i == OP_BIS)
         AST_QUIET_NO_FLAGS: assert (flag_we_o == '0); // R12
      if (!byte_i && (op_i == OP_SUB || op_i == OP_CMP))
         AST_SUB_CARRY_NO_BORROW: assert (flag_o[FLG_C] == (dst_i >= src_i)); // R3
      if (flag_we_o[FLG_Z])
         AST_ZERO_FLAG: assert (flag_o[FLG_Z] == (res_o == '0)); // R9
   end

endmodule

// File: tb/tb_bw_alu.sv
module tb_bw_alu;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] src, dst;
   logic        cin, bsel;
   logic [4:0]  op;
   logic [15:0] res;
   logic        wr;
   logic [3:0]  flg, fwe;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   bw_alu dut (
      .src_i     (src),
      .dst_i     (dst),
      .carry_i   (cin),
      .byte_i    (bsel),
      .op_i      (op),
      .res_o     (res),
      .wr_en_o   (wr),
      .flag_o    (flg),
      .flag_we_o (fwe)
   );

   // vector: {req, op, byte, carry, src, dst, res, wr, flag_we, flags}, flags = {V,N,Z,C}
   localparam int NV = 33;
   localparam logic [67:0] TV [NV] = '{
      {4'd10, 5'h05, 1'b0, 1'b0, 16'h0001, 16'h7FFF, 16'h8000, 1'b1, 4'hF, 4'b1100}, // R10 add overflow
      {4'd2,  5'h05, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'hF, 4'b0011}, // R2 add wrap
      {4'd8,  5'h05, 1'b1, 1'b0, 16'h1280, 16'h3480, 16'h0000, 1'b1, 4'hF, 4'b1011}, // R8 byte add
      {4'd2,  5'h05, 1'b0, 1'b1, 16'h0001, 16'h0001, 16'h0002, 1'b1, 4'hF, 4'b0000}, // R2 carry ignored
      {4'd2,  5'h06, 1'b0, 1'b1, 16'h0010, 16'h0020, 16'h0031, 1'b1, 4'hF, 4'b0000}, // R2 add with carry
      {4'd3,  5'h08, 1'b0, 1'b0, 16'h0007, 16'h0005, 16'hFFFE, 1'b1, 4'hF, 4'b0100}, // R3 sub borrow
      {4'd10, 5'h08, 1'b0, 1'b0, 16'h0001, 16'h8000, 16'h7FFF, 1'b1, 4'hF, 4'b1001}, // R10 sub overflow
      {4'd3,  5'h07, 1'b0, 1'b0, 16'h0003, 16'h0005, 16'h0001, 1'b1, 4'hF, 4'b0001}, // R3 subc
      {4'd1,  5'h09, 1'b0, 1'b0, 16'h1234, 16'h1234, 16'h0000, 1'b0, 4'hF, 4'b0011}, // R1 compare equal
      {4'd8,  5'h09, 1'b1, 1'b0, 16'hCD20, 16'hAB10, 16'h00F0, 1'b0, 4'hF, 4'b0100}, // R8 byte compare
      {4'd4,  5'h0A, 1'b0, 1'b0, 16'h0766, 16'h1234, 16'h2000, 1'b1, 4'h7, 4'b0000}, // R4 bcd ripple
      {4'd4,  5'h0A, 1'b0, 1'b1, 16'h0000, 16'h9999, 16'h0000, 1'b1, 4'h7, 4'b0011}, // R4 bcd overflow
      {4'd4,  5'h0A, 1'b1, 1'b0, 16'h2288, 16'h1199, 16'h0087, 1'b1, 4'h7, 4'b0101}, // R4 byte bcd
      {4'd11, 5'h0F, 1'b0, 1'b0, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b1, 4'hF, 4'b0001}, // R11 and
      {4'd11, 5'h0F, 1'b0, 1'b0, 16'hF000, 16'h0F00, 16'h0000, 1'b1, 4'hF, 4'b0010}, // R11 and zero
      {4'd1,  5'h0B, 1'b1, 1'b0, 16'hFF80, 16'h0080, 16'h0080, 1'b0, 4'hF, 4'b0101}, // R1 bit test
      {4'd11, 5'h0E, 1'b0, 1'b0, 16'h8001, 16'h8003, 16'h0002, 1'b1, 4'hF, 4'b1001}, // R11 xor both neg
      {4'd11, 5'h0E, 1'b0, 1'b0, 16'h8000, 16'h0001, 16'h8001, 1'b1, 4'hF, 4'b0101}, // R11 xor one neg
      {4'd5,  5'h0C, 1'b0, 1'b0, 16'h00FF, 16'h1234, 16'h1200, 1'b1, 4'h0, 4'b0000}, // R5 bit clear
      {4'd5,  5'h0D, 1'b1, 1'b0, 16'h0001, 16'hAB10, 16'h0011, 1'b1, 4'h0, 4'b0000}, // R5 bit set byte
      {4'd12, 5'h04, 1'b0, 1'b1, 16'hBEEF, 16'h1111, 16'hBEEF, 1'b1, 4'h0, 4'b0000}, // R12 move
      {4'd8,  5'h04, 1'b1, 1'b0, 16'hBEEF, 16'h1111, 16'h00EF, 1'b1, 4'h0, 4'b0000}, // R8 byte move
      {4'd6,  5'h10, 1'b0, 1'b1, 16'h0000, 16'h0001, 16'h8000, 1'b1, 4'hF, 4'b0101}, // R6 rrc word
      {4'd6,  5'h10, 1'b1, 1'b0, 16'h0000, 16'hFF02, 16'h0001, 1'b1, 4'hF, 4'b0000}, // R6 rrc byte
      {4'd6,  5'h12, 1'b0, 1'b0, 16'h0000, 16'h8003, 16'hC001, 1'b1, 4'hF, 4'b0101}, // R6 rra word
      {4'd6,  5'h12, 1'b1, 1'b0, 16'h0000, 16'h1281, 16'h00C0, 1'b1, 4'hF, 4'b0101}, // R6 rra byte
      {4'd7,  5'h11, 1'b1, 1'b0, 16'h0000, 16'h12AB, 16'hAB12, 1'b1, 4'h0, 4'b0000}, // R7 swap
      {4'd7,  5'h13, 1'b1, 1'b0, 16'h0000, 16'h0080, 16'hFF80, 1'b1, 4'hF, 4'b0101}, // R7 sxt
      {4'd7,  5'h13, 1'b0, 1'b0, 16'h0000, 16'h1200, 16'h0000, 1'b1, 4'hF, 4'b0010}, // R7 sxt zero
      {4'd1,  5'h02, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 4'h0, 4'b0000}, // R1 undefined
      {4'd1,  5'h17, 1'b1, 1'b0, 16'h1234, 16'h5678, 16'h0000, 1'b0, 4'h0, 4'b0000}, // R1 undefined
      {4'd9,  5'h05, 1'b1, 1'b0, 16'h0001, 16'h007F, 16'h0080, 1'b1, 4'hF, 4'b1100}, // R9 byte sign bit
      {4'd12, 5'h0A, 1'b0, 1'b0, 16'h5000, 16'h5000, 16'h0000, 1'b1, 4'h7, 4'b0011}  // R12 bcd leaves V
   };

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [4:0] o, input logic b, input logic c,
                        input logic [15:0] s, input logic [15:0] d);
      @(negedge clk);
      op = o; bsel = b; cin = c; src = s; dst = d;
      #1;  // combinational: outputs due in the same cycle
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected below 20000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      op = '0; bsel = 1'b0; cin = 1'b0; src = '0; dst = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      #1;
      // idle state: code 0 is undefined (R1)
      chk("R1", "idle res", res, 16'h0000);
      chk("R1", "idle wr", {15'b0, wr}, 16'h0000);
      chk("R1", "idle flag_we", {12'b0, fwe}, 16'h0000);
      chk("R9", "idle flags", {12'b0, flg}, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         logic [67:0] v;
         string       rq;
         v = TV[i];
         rq = $sformatf("R%0d vec%0d", v[67:64], i);
         drive(v[63:59], v[58], v[57], v[56:41], v[40:25]);
         chk(rq, "res", res, v[24:9]);
         chk(rq, "wr", {15'b0, wr}, {15'b0, v[8]});
         chk(rq, "flag_we", {12'b0, fwe}, {12'b0, v[7:4]});
         chk(rq, "flags", {12'b0, flg}, {12'b0, v[3:0]});
      end

      // directed corners
      drive(5'h06, 1'b1, 1'b1, 16'h00FF, 16'h0000);  // R8 byte addc carries out of bit 7
      chk("R8", "addc byte res", res, 16'h0000);
      chk("R8", "addc byte flags", {12'b0, flg}, 16'h0003);
      drive(5'h07, 1'b0, 1'b1, 16'h0003, 16'h0005);  // R3 subc with carry set equals sub
      chk("R3", "subc c=1 res", res, 16'h0002);
      drive(5'h0A, 1'b1, 1'b1, 16'h0000, 16'h0099);  // R4 byte bcd 99+1
      chk("R4", "bcd byte 99+1 res", res, 16'h0000);
      chk("R4", "bcd byte 99+1 flags", {12'b0, flg}, 16'h0003);
      drive(5'h11, 1'b0, 1'b1, 16'hFFFF, 16'h00FF);  // R7 swap word, carry no effect
      chk("R7", "swap word res", res, 16'hFF00);
      chk("R12", "swap flag_we", {12'b0, fwe}, 16'h0000);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule